// File: doc/BRIEF.md
# Power-up Self-Test Sequencer

This block steps a processor through a fixed power-up self-test made of five subsystem checks, run in a fixed order. Each check occupies a fixed number of clock cycles. When that window ends, the block samples the matching bit of a per-check fail input, which is driven by that subsystem's test datapath. After the last check, or straight after the first check that fails, a fixed wrap-up interval runs. The block then raises `done` and presents a 3-bit result code. In the fault register this code occupies the top three bits.

A result code of 000 means every check passed. Any other value names the first check that failed. Two of the checks share one code. The subsystem datapaths themselves are outside this block: it only orders the checks, times them and reports the outcome. The window lengths and the codes are parameters, and their defaults give the production timing.

Top module: `bist_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `busy` = 0, `done` = 0 and `fail_code` = 000.
- R2: A `start` sampled high while idle or while `done` = 1 makes `busy` = 1 and `done` = 0 from the next cycle, and clears `fail_code` to 000.
- R3: `start` has no effect while `busy` = 1. The run length and the final code are the same as without it.
- R4: If no check fails, `busy` stays high for exactly 221+166+214+154+763+26 = 1544 cycles with the default parameters. `done` then rises with `fail_code` = 000.
- R5: The checks run in order 1 to 5, lasting 221, 166, 214, 154 and 763 cycles. Check k is judged at the end of cycle (sum of lengths of checks 1..k) counted from the first busy cycle.
- R6: `chk_fail[k-1]` is sampled only on the last cycle of check k. Its value on any other cycle has no effect.
- R7: The first failing check ends the sequence. Later checks are skipped, and the 26-cycle wrap-up follows at once. The run lasts (sum of lengths of checks 1..k) + 26 cycles.
- R8: `fail_code` (bit 2 = leftmost digit) takes these values: check 1 gives 100, check 2 gives 101, check 3 gives 111, check 4 gives 110, check 5 gives 111. The value is latched when the failing check ends.
- R9: Once `done` = 1, `done` and `fail_code` hold until the next `start`, whatever `chk_fail` does.
- R10: Bits of `chk_fail` that belong to checks other than the one running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle or done |
| chk_fail | input | 5 | Per-check fail flag; bit k-1 belongs to check k |
| busy | output | 1 | High while checks or wrap-up run |
| done | output | 1 | High after completion until next start |
| fail_code | output | 3 | Result code, 000 = pass |

## Verification
The assertions assume that `start` and `chk_fail` are synchronous to `clk` and that every check window is at least one cycle long. They make no assumption about how long `start` is held or about when `chk_fail` toggles. The bench drives all inputs on the falling edge. It holds fail bits high during every non-final cycle of a window, and it pulses `start` in the middle of runs. These patterns test the sampling and start-ignore rules against the timing expected from the window lengths. A small second configuration is swept over every fail pattern, including a one-cycle window.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  localparam int unsigned NPH = 5;

  typedef int unsigned len_arr_t [NPH];
  typedef logic [2:0] code_arr_t [NPH];

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PHASE = 2'd1,
    ST_OVH   = 2'd2,
    ST_DONE  = 2'd3
  } bist_st_e;

  // Longest window among the checks and the wrap-up interval.
  function automatic int unsigned longest(input len_arr_t lens, input int unsigned extra);
    int unsigned m;
    m = extra;
    for (int i = 0; i < NPH; i++) if (lens[i] > m) m = lens[i];
    return m;
  endfunction

  // Bits needed to count 0..m-1 (at least one bit).
  function automatic int unsigned ctr_width(input int unsigned m);
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // Cycles from first busy cycle to done when check 'upto' is the last one run.
  function automatic int unsigned run_cycles(input len_arr_t lens, input int unsigned ovh,
                                             input int unsigned upto);
    int unsigned s;
    s = ovh;
    for (int i = 0; i < NPH; i++) if (i <= int'(upto)) s += lens[i];
    return s;
  endfunction
endpackage

// File: rtl/bist_phase_sel.sv
module bist_phase_sel
  import bist_seq_pkg::*;
#(
  parameter len_arr_t    PH_LEN  = '{221, 166, 214, 154, 763},
  parameter code_arr_t   PH_CODE = '{3'b100, 3'b101, 3'b111, 3'b110, 3'b111},
  parameter int unsigned CW      = 10,
  parameter int unsigned IW      = 3
) (
  input  logic [IW-1:0]  ph_idx,
  output logic [NPH-1:0] ph_onehot,
  output logic [CW-1:0]  ph_last,
  output logic [2:0]     ph_code
);
  logic [CW-1:0] last_tab [NPH];
  logic [2:0]    code_tab [NPH];

  for (genvar i = 0; i < NPH; i++) begin : g_row
    assign ph_onehot[i] = (ph_idx == IW'(i));
    assign last_tab[i]  = CW'(PH_LEN[i] - 1);
    assign code_tab[i]  = PH_CODE[i];
  end

  always_comb begin
    ph_last = '0;
    ph_code = '0;
    for (int i = 0; i < NPH; i++) begin
      if (ph_onehot[i]) begin
        ph_last = ph_last | last_tab[i];
        ph_code = ph_code | code_tab[i];
      end
    end
  end
endmodule

// File: rtl/bist_step_timer.sv
module bist_step_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] last,
  output logic          step_end
);
  logic [CW-1:0] cnt;

  assign step_end = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || step_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_seq_pkg::*;
#(
  parameter len_arr_t    PH_LEN  = '{221, 166, 214, 154, 763},
  parameter code_arr_t   PH_CODE = '{3'b100, 3'b101, 3'b111, 3'b110, 3'b111},
  parameter int unsigned OVH_LEN = 26
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NPH-1:0] chk_fail,
  output logic           busy,
  output logic           done,
  output logic [2:0]     fail_code
);
  localparam int unsigned CW = ctr_width(longest(PH_LEN, OVH_LEN));
  localparam int unsigned IW = ctr_width(NPH);
  localparam logic [IW-1:0] LAST_PH = IW'(NPH - 1);
  localparam logic [CW-1:0] OVH_LAST = CW'(OVH_LEN - 1);

  bist_st_e       st;
  logic [IW-1:0]  ph_idx;
  logic [NPH-1:0] ph_onehot;
  logic [CW-1:0]  ph_last;
  logic [2:0]     ph_code;
  logic [CW-1:0]  step_last;
  logic           step_end;

  // Named internal events (also observed by the bound checker).
  logic ph_end;
  logic ovh_end;
  logic fail_hit;
  logic start_take;

  bist_phase_sel #(
    .PH_LEN (PH_LEN),
    .PH_CODE(PH_CODE),
    .CW     (CW),
    .IW     (IW)
  ) u_sel (
    .ph_idx   (ph_idx),
    .ph_onehot(ph_onehot),
    .ph_last  (ph_last),
    .ph_code  (ph_code)
  );

  assign busy      = (st == ST_PHASE) || (st == ST_OVH);
  assign done      = (st == ST_DONE);
  assign step_last = (st == ST_OVH) ? OVH_LAST : ph_last;

  bist_step_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .last    (step_last),
    .step_end(step_end)
  );

  assign ph_end     = (st == ST_PHASE) && step_end;
  assign ovh_end    = (st == ST_OVH) && step_end;
  assign fail_hit   = |(ph_onehot & chk_fail);
  assign start_take = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph_idx    <= '0;
      fail_code <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start_take) begin
            st        <= ST_PHASE;
            ph_idx    <= '0;
            fail_code <= '0;
          end
        end
        ST_PHASE: begin
          if (ph_end) begin
            if (fail_hit) begin
              fail_code <= ph_code;
              st        <= ST_OVH;
            end else if (ph_idx == LAST_PH) begin
              st <= ST_OVH;
            end else begin
              ph_idx <= ph_idx + IW'(1);
            end
          end
        end
        ST_OVH: begin
          if (ovh_end) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] fail_code,
  input logic       ph_end,
  input logic       ovh_end,
  input logic       fail_hit
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && fail_code == 3'b000); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ovh_end |=> busy); // R3

  AST_WRAP_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_end |=> done && !busy); // R4

  AST_CODE_AT_PHASE_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(fail_code) |-> $past(ph_end && fail_hit)); // R6

  AST_FAIL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ph_end && fail_hit |=> !ph_end && busy); // R7

  AST_FAIL_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ph_end && fail_hit |=> fail_code != 3'b000); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(fail_code)); // R9
endmodule

bind bist_seq bist_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .fail_code(fail_code),
  .ph_end   (ph_end),
  .ovh_end  (ovh_end),
  .fail_hit (fail_hit)
);

// File: tb/tb_bist_seq.sv
module tb_bist_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       start_b, start_s;
  logic [4:0] chk_b, chk_s;
  logic       busy_b, busy_s, done_b, done_s;
  logic [2:0] code_b, code_s;
  int n_chk = 0;
  int n_fail = 0;

  bist_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start_b), .chk_fail(chk_b),
    .busy(busy_b), .done(done_b), .fail_code(code_b)
  );

  bist_seq #(
    .PH_LEN ('{3, 2, 4, 1, 5}),
    .OVH_LEN(2)
  ) dut_small (
    .clk(clk), .rst_n(rst_n), .start(start_s), .chk_fail(chk_s),
    .busy(busy_s), .done(done_s), .fail_code(code_s)
  );

  function automatic int lenof(bit big, int p);
    int lb [5] = '{221, 166, 214, 154, 763};
    int ls [5] = '{3, 2, 4, 1, 5};
    return big ? lb[p] : ls[p];
  endfunction

  function automatic int ovhof(bit big);
    return big ? 26 : 2;
  endfunction

  function automatic logic [2:0] code_of(int p);
    case (p)
      0: return 3'd4;
      1: return 3'd5;
      3: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic g_busy(bit big); return big ? busy_b : busy_s; endfunction
  function automatic logic g_done(bit big); return big ? done_b : done_s; endfunction
  function automatic logic [2:0] g_code(bit big); return big ? code_b : code_s; endfunction

  task automatic drive(bit big, logic st, logic [4:0] v);
    if (big) begin start_b = st; chk_b = v; end
    else     begin start_s = st; chk_s = v; end
  endtask

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic run_case(bit big, logic [4:0] fmask, bit glitch, bit poke);
    int cum [6];
    int first = -1;
    int n, j;
    bit dropped = 1'b0;
    logic [2:0] expc;
    cum[0] = 0;
    for (int p = 0; p < 5; p++) cum[p+1] = cum[p] + lenof(big, p);
    for (int p = 4; p >= 0; p--) if (fmask[p]) first = p;
    n    = (first < 0) ? cum[5] + ovhof(big) : cum[first+1] + ovhof(big);
    expc = (first < 0) ? 3'd0 : code_of(first);

    @(negedge clk); drive(big, 1'b1, 5'h00);
    @(negedge clk); drive(big, 1'b0, 5'h00);
    // R2: busy next cycle, done low, code cleared
    check(g_busy(big) && !g_done(big) && g_code(big) == 3'd0, "R2",
          {g_busy(big), g_done(big), g_code(big)}, 5'b10000, "state after start");
    j = 0;
    while (!g_done(big) && j < 5000) begin
      bit lastc = 1'b0;
      logic [4:0] v;
      for (int p = 0; p < 5; p++) if (j == cum[p+1] - 1) lastc = 1'b1;
      v = glitch ? (lastc ? fmask : 5'h1f) : fmask;
      if (!g_busy(big)) dropped = 1'b1;
      drive(big, poke && (j == 1 || j == 2 || j == cum[1]), v);
      @(negedge clk);
      j++;
    end
    check(!dropped, "R3", dropped, 0, "busy dropped before done");
    check(j == n, (first < 0) ? "R4" : "R5 R7", j, n, "run length");
    check(g_code(big) == expc, "R8 R10", g_code(big), expc, "fail code");
    check(!g_busy(big), "R4", g_busy(big), 0, "busy at done");
    // R9: result holds while fail inputs toggle and start is low
    for (int k = 0; k < 3; k++) begin
      drive(big, 1'b0, (k[0]) ? 5'h1f : 5'h0a);
      @(negedge clk);
      check(g_done(big) && g_code(big) == expc, "R9", {g_done(big), g_code(big)},
            {1'b1, expc}, "done hold");
    end
    // R6: glitch cases must depend only on last-cycle values
    if (glitch) check(g_code(big) == expc, "R6", g_code(big), expc, "non-final cycles ignored");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 5'h00);
    drive(1'b0, 1'b0, 5'h00);
    repeat (3) @(negedge clk);
    check(!busy_b && !done_b && code_b == 3'd0, "R1", {busy_b, done_b, code_b}, 0, "reset state");
    check(!busy_s && !done_s && code_s == 3'd0, "R1", {busy_s, done_s, code_s}, 0, "reset state small");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_b && !done_b && code_b == 3'd0, "R1", {busy_b, done_b, code_b}, 0, "idle after reset");

    run_case(1'b1, 5'b00000, 1'b0, 1'b0);
    for (int p = 0; p < 5; p++) run_case(1'b1, 5'(1 << p), 1'b0, 1'b0);
    run_case(1'b1, 5'b10100, 1'b1, 1'b1);
    run_case(1'b1, 5'b00000, 1'b1, 1'b1);

    for (int m = 0; m < 32; m++)
      for (int g = 0; g < 2; g++)
        run_case(1'b0, 5'(m), g[0], g[0] ^ m[0]);

    report();
    $finish;
  end
endmodule